// File: doc/BRIEF.md
# Coherent Sensor Reading Register Bank

This block holds the latest conversion results of a hardware monitor: an 8-bit upper byte for each voltage and temperature channel, and two low-resolution registers that pack the two extra bits of every channel in a group. A measurement engine writes results through a one-cycle write port that carries the channel number, the upper byte, the two low bits and a diode-fault flag. A host reads the bank through a byte-addressed register port. Read data is registered.

A multi-byte value must come from a single conversion. For that reason, reading a group's low-resolution register freezes that register and every upper-byte register of its group. While the group is frozen, new results for it are dropped. The group thaws once the host has read every upper byte of the group, in any order. Each group owns a small state machine with two states. `FZ_TRACK` accepts results. `FZ_FROZEN` drops them and keeps a mask of the upper bytes still unread. The transition *freeze* goes from `FZ_TRACK` to `FZ_FROZEN` on a read of the group's low-resolution register. The transition *thaw* goes from `FZ_FROZEN` to `FZ_TRACK` on the read that empties the mask. Another read of the low-resolution register in `FZ_FROZEN` is a self-loop that changes nothing.

Temperatures are stored as two's complement. They are presented either in that form or as offset-64 binary, under a configuration bit. A diode fault reads as a reserved code. A sticky lock bit makes the configuration register read-only until reset.

Top module: `sensor_regbank`

## Requirements
- R1: After reset, the temperature upper bytes read 0x80, the voltage upper bytes read 0x00, both low-resolution registers read 0x00 and the configuration register reads 0x00.
- R2: A measurement write stores the upper byte and the low bits of its channel while that channel's group is in `FZ_TRACK`. Channels 0 to 3 are voltages and channels 4 to 6 are temperatures 0 to 2. Voltage i reads at 0x00+i and temperature j reads at 0x08+j. The voltage low bits read at 0x10 and the temperature low bits read at 0x11, with channel k of the group in bits [2k+1:2k].
- R3: A host read of a group's low-resolution register freezes that group. Measurement writes to the group in the same cycle as that read, and in every later cycle while it stays frozen, are discarded. The other group keeps updating.
- R4: A frozen group thaws after each of its upper bytes has been read at least once, in any order. A write in the cycle of the last such read is discarded. The first write after that is stored.
- R5: Reading an upper byte while its group is in `FZ_TRACK` does not freeze the group.
- R6: Configuration bit 0 selects the temperature encoding. A value of 0 gives the stored two's complement byte. A value of 1 gives offset-64, that is the temperature plus 64, and any temperature of −63 or lower reads 0x01.
- R7: A temperature write with the fault flag set makes that channel read 0x80 in two's complement mode and 0x00 in offset-64 mode, and clears its low bits to 00. The next write without the flag clears the fault.
- R8: Configuration bit 1 is the lock. While it is set, host writes to the configuration register are ignored, so the lock can only be cleared by reset.
- R9: Read data appears one cycle after the read strobe. The configuration register reads at 0x20 as {6'b0, lock, format}. Any address that is not mapped reads 0x00.
- R10: Host writes to the reading registers (0x00 to 0x11) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| meas_we | input | 1 | Measurement write strobe |
| meas_ch | input | 3 | Channel number (0-3 voltage, 4-6 temperature) |
| meas_hi | input | 8 | Upper byte of the result |
| meas_lo | input | 2 | Two low resolution bits |
| meas_fault | input | 1 | Diode fault flag (temperature channels only) |
| host_addr | input | 8 | Register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |

## Verification
The bench tries to break coherence in four ways:
- It writes to a group in the same cycle as the low-resolution read. A design that froze one cycle late would return low bits that do not match the upper byte.
- It writes in the cycle of the final upper-byte read and right after it. This catches a thaw that is early or late by one cycle.
- It reads the upper bytes out of order and leaves one unread. A design that thawed on the first upper-byte read would take new data too soon.
- It writes to the other group while one group is frozen, which catches a freeze that spreads across groups.

Encoding is checked at the offset-64 boundaries, including the clamp to 0x01 and a value that encodes as 0x80. It is also checked against both fault codes. The lock is checked by trying to clear it and by trying to change the format while it is set, either of which a non-sticky lock would allow.

// File: rtl/sbank_pkg.sv
package sbank_pkg;
    typedef enum logic {
        FZ_TRACK  = 1'b0,
        FZ_FROZEN = 1'b1
    } fz_state_e;

    localparam logic [7:0] VOLT_BASE  = 8'h00;
    localparam logic [7:0] TEMP_BASE  = 8'h08;
    localparam logic [7:0] LOW_VOLT   = 8'h10;
    localparam logic [7:0] LOW_TEMP   = 8'h11;
    localparam logic [7:0] CFG_ADDR   = 8'h20;
    localparam logic [7:0] TEMP_RESET = 8'h80;
    localparam logic [7:0] FAULT_TWOS = 8'h80;
    localparam logic [7:0] FAULT_OFS  = 8'h00;
endpackage

// File: rtl/sbank_freeze_fsm.sv
module sbank_freeze_fsm
    import sbank_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         low_rd,
    input  logic [N-1:0] hi_rd,
    output logic         accept,
    output logic         frozen
);
    fz_state_e    state, state_n;
    logic [N-1:0] pend, pend_n;

    always_comb begin
        state_n = state;
        pend_n  = pend;
        unique case (state)
            FZ_TRACK: begin
                if (low_rd) begin
                    state_n = FZ_FROZEN;
                    pend_n  = '1;
                end
            end
            FZ_FROZEN: begin
                pend_n = pend & ~hi_rd;
                if (pend_n == '0) state_n = FZ_TRACK;
            end
            default: state_n = FZ_TRACK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FZ_TRACK;
            pend  <= '0;
        end else begin
            state <= state_n;
            pend  <= pend_n;
        end
    end

    always_comb begin
        accept = (state == FZ_TRACK) && !low_rd;
        frozen = (state == FZ_FROZEN);
    end
endmodule

// File: rtl/sbank_temp_encode.sv
module sbank_temp_encode
    import sbank_pkg::*;
(
    input  logic [7:0] raw,
    input  logic       fault,
    input  logic       ofs_mode,
    output logic [7:0] code
);
    logic signed [8:0] shifted;

    always_comb begin
        shifted = $signed({raw[7], raw}) + 9'sd64;
        if (fault)
            code = ofs_mode ? FAULT_OFS : FAULT_TWOS;
        else if (!ofs_mode)
            code = raw;
        else if (shifted < 9'sd1)
            code = 8'h01;
        else
            code = shifted[7:0];
    end
endmodule

// File: rtl/sensor_regbank.sv
module sensor_regbank
    import sbank_pkg::*;
#(
    parameter int NUM_VOLT = 4,
    parameter int NUM_TEMP = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  meas_we,
    input  logic [$clog2(NUM_VOLT+NUM_TEMP)-1:0]  meas_ch,
    input  logic [7:0]                            meas_hi,
    input  logic [1:0]                            meas_lo,
    input  logic                                  meas_fault,
    input  logic [7:0]                            host_addr,
    input  logic                                  host_wr,
    input  logic                                  host_rd,
    input  logic [7:0]                            host_wdata,
    output logic [7:0]                            host_rdata
);
    // Each group packs 2 bits per channel into one byte, so at most 4 channels per group.
    localparam int NCH  = NUM_VOLT + NUM_TEMP;
    localparam int CH_W = $clog2(NCH);

    logic [7:0]          hi_q  [NCH];
    logic [1:0]          lo_q  [NCH];
    logic [NUM_TEMP-1:0] flt_q;
    logic [7:0]          tcode [NUM_TEMP];
    logic                fmt_q, lock_q;
    logic [NUM_VOLT-1:0] v_hi_rd;
    logic [NUM_TEMP-1:0] t_hi_rd;
    logic                v_low_rd, t_low_rd;
    logic                v_accept, t_accept, v_frozen, t_frozen;
    logic [7:0]          low_v, low_t, rd_mux;
    logic [8*NUM_VOLT-1:0] v_hi_flat;
    logic [8*NUM_TEMP-1:0] t_hi_flat;
    logic [NUM_TEMP-1:0]   t_flt_flat;
    logic [5:0]          unused_wdata_hi;

    assign unused_wdata_hi = host_wdata[7:2];
    assign v_low_rd = host_rd && (host_addr == LOW_VOLT);
    assign t_low_rd = host_rd && (host_addr == LOW_TEMP);
    assign t_flt_flat = flt_q;

    // Group state machines
    sbank_freeze_fsm #(.N(NUM_VOLT)) u_fz_volt (
        .clk(clk), .rst_n(rst_n), .low_rd(v_low_rd), .hi_rd(v_hi_rd),
        .accept(v_accept), .frozen(v_frozen));
    sbank_freeze_fsm #(.N(NUM_TEMP)) u_fz_temp (
        .clk(clk), .rst_n(rst_n), .low_rd(t_low_rd), .hi_rd(t_hi_rd),
        .accept(t_accept), .frozen(t_frozen));

    // Channel storage
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam bit IS_T = (c >= NUM_VOLT);
        logic take;
        assign take = meas_we && (meas_ch == CH_W'(c)) && (IS_T ? t_accept : v_accept);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q[c] <= IS_T ? TEMP_RESET : 8'h00;
                lo_q[c] <= 2'b00;
            end else if (take) begin
                hi_q[c] <= meas_hi;
                lo_q[c] <= (IS_T && meas_fault) ? 2'b00 : meas_lo;
            end
        end
    end

    for (genvar v = 0; v < NUM_VOLT; v++) begin : g_volt
        assign v_hi_rd[v] = host_rd && (host_addr == VOLT_BASE + 8'(v));
        assign v_hi_flat[8*v +: 8] = hi_q[v];
    end

    for (genvar t = 0; t < NUM_TEMP; t++) begin : g_temp
        localparam int CI = NUM_VOLT + t;
        assign t_hi_rd[t] = host_rd && (host_addr == TEMP_BASE + 8'(t));
        assign t_hi_flat[8*t +: 8] = hi_q[CI];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flt_q[t] <= 1'b0;
            else if (meas_we && (meas_ch == CH_W'(CI)) && t_accept)
                flt_q[t] <= meas_fault;
        end
        sbank_temp_encode u_enc (
            .raw(hi_q[CI]), .fault(flt_q[t]), .ofs_mode(fmt_q), .code(tcode[t]));
    end

    // Packed low-resolution bytes
    always_comb begin
        low_v = 8'h00;
        low_t = 8'h00;
        for (int i = 0; i < NUM_VOLT; i++) low_v[2*i +: 2] = lo_q[i];
        for (int j = 0; j < NUM_TEMP; j++) low_t[2*j +: 2] = lo_q[NUM_VOLT + j];
    end

    // Configuration: format and sticky lock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q  <= 1'b0;
            lock_q <= 1'b0;
        end else if (host_wr && (host_addr == CFG_ADDR) && !lock_q) begin
            fmt_q  <= host_wdata[0];
            lock_q <= host_wdata[1];
        end
    end

    // Read decode
    always_comb begin
        rd_mux = 8'h00;
        for (int i = 0; i < NUM_VOLT; i++)
            if (host_addr == VOLT_BASE + 8'(i)) rd_mux = hi_q[i];
        for (int j = 0; j < NUM_TEMP; j++)
            if (host_addr == TEMP_BASE + 8'(j)) rd_mux = tcode[j];
        if (host_addr == LOW_VOLT) rd_mux = low_v;
        if (host_addr == LOW_TEMP) rd_mux = low_t;
        if (host_addr == CFG_ADDR) rd_mux = {6'b0, lock_q, fmt_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            host_rdata <= 8'h00;
        else if (host_rd)
            host_rdata <= rd_mux;
    end
endmodule

// File: rtl/sbank_checker.sv
module sbank_checker
    import sbank_pkg::*;
#(
    parameter int NUM_VOLT = 4,
    parameter int NUM_TEMP = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  host_rd,
    input logic                  host_wr,
    input logic [7:0]            host_addr,
    input logic [7:0]            host_rdata,
    input logic                  v_frozen,
    input logic                  t_frozen,
    input logic [8*NUM_VOLT-1:0] v_hi_flat,
    input logic [8*NUM_TEMP-1:0] t_hi_flat,
    input logic [NUM_TEMP-1:0]   t_flt_flat,
    input logic [7:0]            low_v,
    input logic [7:0]            low_t,
    input logic                  fmt_q,
    input logic                  lock_q
);
    p_low_rd_freezes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && (host_addr == LOW_VOLT) |=> v_frozen);

    p_volt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        v_frozen |=> $stable({v_hi_flat, low_v}));

    p_temp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        t_frozen |=> $stable({t_hi_flat, t_flt_flat, low_t}));

    p_hi_rd_no_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !v_frozen && host_rd && (host_addr == VOLT_BASE) |=> !v_frozen);

    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    p_locked_fmt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q && host_wr |=> $stable(fmt_q));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && (host_addr > CFG_ADDR) |=> host_rdata == 8'h00);
endmodule

bind sensor_regbank sbank_checker #(.NUM_VOLT(NUM_VOLT), .NUM_TEMP(NUM_TEMP)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_rdata(host_rdata),
    .v_frozen(v_frozen), .t_frozen(t_frozen),
    .v_hi_flat(v_hi_flat), .t_hi_flat(t_hi_flat), .t_flt_flat(t_flt_flat),
    .low_v(low_v), .low_t(low_t), .fmt_q(fmt_q), .lock_q(lock_q));

// File: tb/tb_sensor_regbank.sv
`timescale 1ns/1ps
module tb_sensor_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       meas_we = 1'b0;
    logic [2:0] meas_ch = '0;
    logic [7:0] meas_hi = '0;
    logic [1:0] meas_lo = '0;
    logic       meas_fault = 1'b0;
    logic [7:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    sensor_regbank dut (
        .clk(clk), .rst_n(rst_n), .meas_we(meas_we), .meas_ch(meas_ch),
        .meas_hi(meas_hi), .meas_lo(meas_lo), .meas_fault(meas_fault),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata));

    // Monitor: pops one expectation per read strobe, compares half a cycle after the edge
    initial begin
        forever begin
            @(posedge clk);
            if (host_rd) begin
                @(negedge clk);
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard empty actual=%02h expected=none", host_rdata);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (host_rdata !== e) begin
                        errors++;
                        $display("FAIL %s actual=%02h expected=%02h", t, host_rdata, e);
                    end
                end
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic meas(input int ch, input logic [7:0] h, input logic [1:0] l, input logic f);
        @(negedge clk);
        meas_ch = 3'(ch); meas_hi = h; meas_lo = l; meas_fault = f; meas_we = 1'b1;
        @(negedge clk);
        meas_we = 1'b0; meas_fault = 1'b0;
    endtask

    // Read and measurement write in the same cycle
    task automatic rd_meas(input logic [7:0] a, input logic [7:0] e, input string t,
                           input int ch, input logic [7:0] h, input logic [1:0] l);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        meas_ch = 3'(ch); meas_hi = h; meas_lo = l; meas_fault = 1'b0; meas_we = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; meas_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R9 unmapped
        rd(8'h00, 8'h00, "R1 volt0 reset");
        rd(8'h08, 8'h80, "R1 temp0 reset");
        rd(8'h0A, 8'h80, "R1 temp2 reset");
        rd(8'h20, 8'h00, "R1 config reset");
        rd(8'h30, 8'h00, "R9 unmapped");
        rd(8'h10, 8'h00, "R1 volt low reset");
        rd(8'h00, 8'h00, "R4 thaw read v0");
        rd(8'h01, 8'h00, "R4 thaw read v1");
        rd(8'h02, 8'h00, "R4 thaw read v2");
        rd(8'h03, 8'h00, "R4 thaw read v3");

        // R2 store, R5 upper read does not freeze
        meas(1, 8'hA5, 2'b10, 1'b0);
        rd(8'h01, 8'hA5, "R2 volt1 stored");
        meas(1, 8'hB6, 2'b01, 1'b0);
        rd(8'h01, 8'hB6, "R5 volt1 still updating");

        // R3 freeze
        rd(8'h10, 8'h04, "R2 volt low packing");
        meas(1, 8'hC7, 2'b11, 1'b0);
        meas(0, 8'h11, 2'b11, 1'b0);
        meas(4, 8'h19, 2'b01, 1'b0);
        rd(8'h08, 8'h19, "R3 other group updates");
        rd(8'h10, 8'h04, "R3 low held while frozen");
        rd(8'h01, 8'hB6, "R3 volt1 held");
        rd(8'h00, 8'h00, "R3 volt0 held");
        rd(8'h02, 8'h00, "R4 partial read v2");
        meas(1, 8'hD8, 2'b00, 1'b0);
        rd(8'h01, 8'hB6, "R4 still frozen with v3 unread");
        rd(8'h03, 8'h00, "R4 last read v3");
        meas(1, 8'hE9, 2'b10, 1'b0);
        rd(8'h01, 8'hE9, "R4 first write after thaw");

        // R3 same-cycle write discarded, R4 last-read-cycle write discarded
        rd_meas(8'h11, 8'h01, "R3 temp low old value", 4, 8'h20, 2'b11);
        rd(8'h08, 8'h19, "R3 same-cycle write dropped");
        rd(8'h09, 8'h80, "R4 thaw read t1");
        rd_meas(8'h0A, 8'h80, "R4 thaw read t2", 4, 8'h21, 2'b00);
        rd(8'h08, 8'h19, "R4 last-read-cycle write dropped");
        meas(4, 8'h30, 2'b00, 1'b0);
        rd(8'h08, 8'h30, "R4 write after thaw stored");

        // R6 offset-64
        wr(8'h20, 8'h01);
        rd(8'h20, 8'h01, "R9 config readback");
        rd(8'h08, 8'h70, "R6 offset 48C");
        meas(4, 8'hE7, 2'b00, 1'b0);
        rd(8'h08, 8'h27, "R6 offset -25C");
        meas(4, 8'h9C, 2'b00, 1'b0);
        rd(8'h08, 8'h01, "R6 offset clamp -100C");
        rd(8'h09, 8'h01, "R6 offset clamp reset value");
        meas(6, 8'h40, 2'b11, 1'b0);
        rd(8'h0A, 8'h80, "R6 offset 64C");

        // R7 fault codes
        meas(6, 8'h55, 2'b11, 1'b1);
        rd(8'h0A, 8'h00, "R7 fault offset code");
        rd(8'h11, 8'h00, "R7 fault clears low bits");
        rd(8'h08, 8'h01, "R4 thaw read t0");
        rd(8'h09, 8'h01, "R4 thaw read t1");
        rd(8'h0A, 8'h00, "R4 thaw read t2");
        wr(8'h20, 8'h00);
        rd(8'h0A, 8'h80, "R7 fault twos code");
        rd(8'h08, 8'h9C, "R6 twos raw");

        // R10 reading registers are read-only
        wr(8'h08, 8'h55);
        wr(8'h01, 8'h00);
        rd(8'h08, 8'h9C, "R10 temp0 unchanged");
        rd(8'h01, 8'hE9, "R10 volt1 unchanged");

        // R8 lock
        wr(8'h20, 8'h03);
        rd(8'h20, 8'h03, "R8 lock set");
        wr(8'h20, 8'h00);
        rd(8'h20, 8'h03, "R8 lock sticky");
        meas(4, 8'h7F, 2'b00, 1'b0);
        rd(8'h08, 8'hBF, "R8 format kept under lock");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 missing read data actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule